// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. A request is presented with a one-cycle `start` pulse, together with the access kind (read or write), the privilege of the requester (user or supervisor), a paging-enable bit and the physical base of the page directory. When paging is off, the address passes straight through. When paging is on, the walker fetches one directory entry and then one page-table entry over a simple request/ready memory port.

The walker checks each fetched entry for presence, reserved bits, write permission and user access. When an entry passes these checks, the walker writes the entry back with its accessed flag set. On a write access it also sets the dirty flag, and only in the page-table entry. A write-back is skipped when the flags are already set. The walk ends with a one-cycle `done` pulse. With it come either the physical address and the caching attributes of the page, or a fault flag and a 4-bit fault code.

Entries are 32-bit words. Bits 31:12 of an entry hold a frame number. Bits 11:9 are free for software and are ignored. Bits 8:7 must be zero.

Top module: `pt_walker`

## Requirements
- R1: When `pagingEn` is 0, a `start` seen while idle gives `done` on the next cycle with `physAddr` equal to `linAddr`, `fault` 0, and no memory request.
- R2: The directory entry is read from {dirBase[31:12], linAddr[31:22], 2'b00}. The table entry is read from {directory entry[31:12], linAddr[21:12], 2'b00}.
- R3: On a successful walk, `physAddr` is {table entry[31:12], linAddr[11:0]}.
- R4: An entry at either level with bit 0 (present) clear ends the walk with a fault. Fault code bit 0 is then 0, and nothing further is read or written.
- R5: A write through an entry at either level whose bit 1 (writable) is clear ends the walk with a fault, and fault code bit 0 is 1.
- R6: A user access through an entry at either level whose bit 2 (user allowed) is clear ends the walk with a fault, and fault code bit 0 is 1.
- R7: When a present, permitted entry at either level has bit 5 (accessed) clear, it is written back to its own address with bit 5 set. If bit 5 is already set, no write is made.
- R8: On a write access, the table entry is written back with bit 6 (dirty) set when that bit is clear. The directory entry never has bit 6 set by the walker.
- R9: A present entry with bit 7 or bit 8 non-zero ends the walk with a fault, and fault code bits 3 and 0 are both 1. A not-present fault takes priority over a reserved-bit fault, and a reserved-bit fault takes priority over a permission fault.
- R10: Fault code bit 1 equals the write flag of the request, and bit 2 equals the user flag.
- R11: On success, `cacheDis` is bit 4 and `writeThru` is bit 3 of the table entry. Both are 0 after a fault or a pass-through.
- R12: `memReq` stays high with `memAddr`, `memWe` and `memWdata` stable until `memReady` is seen. `done` lasts one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a translation (accepted when idle) |
| linAddr | input | 32 | Linear address to translate |
| isWrite | input | 1 | 1 for a write access |
| isUser | input | 1 | 1 for a user-mode access |
| pagingEn | input | 1 | 1 enables translation |
| dirBase | input | 32 | Physical base of the page directory (bits 31:12 used) |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 for a memory write |
| memAddr | output | 32 | Byte address of the entry |
| memWdata | output | 32 | Entry value written back |
| memReady | input | 1 | Memory completes the request this cycle |
| memRdata | input | 32 | Entry read, valid with `memReady` |
| physAddr | output | 32 | Translated address |
| cacheDis | output | 1 | Page is not cacheable |
| writeThru | output | 1 | Page uses write-through |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Completion was a page fault |
| faultCode | output | 4 | {reserved, user, write, present-but-denied} |

## Verification
On every cycle, the assertions check the memory handshake (a request is held stable until ready), that `done` is a single pulse, the pass-through timing and result, that no request is raised while idle, that every write-back carries the accessed flag, and the consistency of the fault code with the attributes. The walk's outcome depends on entry contents, so only the bench scenarios can show it: the entry addresses at each level, the fault priorities, which entries are rewritten and with what value, and whether redundant write-backs are skipped. The bench checks these by predicting the resulting memory image and the number of reads and writes of each walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  // entry flag positions (behavioural: software and walker agree on them)
  localparam int BIT_PRESENT  = 0;
  localparam int BIT_WRITE    = 1;
  localparam int BIT_USER     = 2;
  localparam int BIT_WTHRU    = 3;
  localparam int BIT_NOCACHE  = 4;
  localparam int BIT_ACCESSED = 5;
  localparam int BIT_DIRTY    = 6;
  localparam int RSV_LO       = 7;
  localparam int RSV_HI       = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_DIR, ST_CHK_DIR, ST_WB_DIR, ST_RD_TBL, ST_CHK_TBL, ST_WB_TBL
  } walkState_t;

  typedef struct packed {
    logic capture;
    logic loadEntry;
    logic tableLevel;
    logic finishXlate;
    logic finishBypass;
    logic finishFault;
  } walkStrobe_t;

  typedef struct packed {
    logic notPresent;
    logic reserved;
    logic protect;
    logic needWb;
  } entryStatus_t;
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         pagingEn,
  input  logic         memReady,
  input  entryStatus_t status,
  output walkStrobe_t  strb,
  output logic         memReq,
  output logic         memWe,
  output logic         walkBusy
);
  walkState_t state, nextState;
  logic entryBad;

  assign entryBad = status.notPresent | status.reserved | status.protect;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    strb.tableLevel = (state == ST_RD_TBL) || (state == ST_CHK_TBL) || (state == ST_WB_TBL);
    memReq    = (state == ST_RD_DIR) || (state == ST_WB_DIR) ||
                (state == ST_RD_TBL) || (state == ST_WB_TBL);
    memWe     = (state == ST_WB_DIR) || (state == ST_WB_TBL);
    walkBusy  = (state != ST_IDLE);
    unique case (state)
      ST_IDLE: if (start) begin
        strb.capture = 1'b1;
        if (pagingEn) nextState = ST_RD_DIR;
        else          strb.finishBypass = 1'b1;
      end
      ST_RD_DIR: if (memReady) begin
        strb.loadEntry = 1'b1;
        nextState = ST_CHK_DIR;
      end
      ST_CHK_DIR: begin
        if (entryBad) begin
          strb.finishFault = 1'b1;
          nextState = ST_IDLE;
        end else if (status.needWb) nextState = ST_WB_DIR;
        else                        nextState = ST_RD_TBL;
      end
      ST_WB_DIR: if (memReady) nextState = ST_RD_TBL;
      ST_RD_TBL: if (memReady) begin
        strb.loadEntry = 1'b1;
        nextState = ST_CHK_TBL;
      end
      ST_CHK_TBL: begin
        if (entryBad) begin
          strb.finishFault = 1'b1;
          nextState = ST_IDLE;
        end else if (status.needWb) nextState = ST_WB_TBL;
        else begin
          strb.finishXlate = 1'b1;
          nextState = ST_IDLE;
        end
      end
      ST_WB_TBL: if (memReady) begin
        strb.finishXlate = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strb,
  input  logic [ADDR_W-1:0] linAddr,
  input  logic              isWrite,
  input  logic              isUser,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic [ADDR_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  output entryStatus_t      status,
  output logic [ADDR_W-1:0] physAddr,
  output logic              cacheDis,
  output logic              writeThru,
  output logic              done,
  output logic              fault,
  output logic [3:0]        faultCode
);
  localparam int FRAME_W = ADDR_W - OFF_W;
  localparam int ENT_LSB = OFF_W - IDX_W;   // byte-offset bits of one entry

  logic [ADDR_W-1:0]  linQ, pdeQ, pteQ, curEntry;
  logic [FRAME_W-1:0] baseFrameQ;
  logic               wrQ, usrQ;
  logic [IDX_W-1:0]   dirIdx, tblIdx;

  assign dirIdx   = linQ[ADDR_W-1 -: IDX_W];
  assign tblIdx   = linQ[OFF_W +: IDX_W];
  assign curEntry = strb.tableLevel ? pteQ : pdeQ;

  always_comb begin
    if (strb.tableLevel) memAddr = {pdeQ[ADDR_W-1:OFF_W], tblIdx, {ENT_LSB{1'b0}}};
    else                 memAddr = {baseFrameQ, dirIdx, {ENT_LSB{1'b0}}};
    memWdata = curEntry;
    memWdata[BIT_ACCESSED] = 1'b1;
    if (strb.tableLevel && wrQ) memWdata[BIT_DIRTY] = 1'b1;
    status.notPresent = !curEntry[BIT_PRESENT];
    status.reserved   = |curEntry[RSV_HI:RSV_LO];
    status.protect    = (wrQ && !curEntry[BIT_WRITE]) || (usrQ && !curEntry[BIT_USER]);
    status.needWb     = (memWdata != curEntry);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linQ <= '0; pdeQ <= '0; pteQ <= '0; baseFrameQ <= '0;
      wrQ <= 1'b0; usrQ <= 1'b0;
    end else begin
      if (strb.capture) begin
        linQ       <= linAddr;
        wrQ        <= isWrite;
        usrQ       <= isUser;
        baseFrameQ <= dirBase[ADDR_W-1:OFF_W];
      end
      if (strb.loadEntry) begin
        if (strb.tableLevel) pteQ <= memRdata;
        else                 pdeQ <= memRdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      physAddr <= '0; cacheDis <= 1'b0; writeThru <= 1'b0;
      done <= 1'b0; fault <= 1'b0; faultCode <= '0;
    end else begin
      done <= strb.finishXlate | strb.finishBypass | strb.finishFault;
      if (strb.finishBypass) begin
        physAddr  <= linAddr;
        cacheDis  <= 1'b0;
        writeThru <= 1'b0;
        fault     <= 1'b0;
        faultCode <= '0;
      end else if (strb.finishXlate) begin
        physAddr  <= {pteQ[ADDR_W-1:OFF_W], linQ[OFF_W-1:0]};
        cacheDis  <= pteQ[BIT_NOCACHE];
        writeThru <= pteQ[BIT_WTHRU];
        fault     <= 1'b0;
        faultCode <= '0;
      end else if (strb.finishFault) begin
        physAddr  <= '0;
        cacheDis  <= 1'b0;
        writeThru <= 1'b0;
        fault     <= 1'b1;
        faultCode <= {status.reserved & !status.notPresent, usrQ, wrQ, !status.notPresent};
      end
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] linAddr,
  input  logic              isWrite,
  input  logic              isUser,
  input  logic              pagingEn,
  input  logic [ADDR_W-1:0] dirBase,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  input  logic              memReady,
  input  logic [ADDR_W-1:0] memRdata,
  output logic [ADDR_W-1:0] physAddr,
  output logic              cacheDis,
  output logic              writeThru,
  output logic              done,
  output logic              fault,
  output logic [3:0]        faultCode
);
  walkStrobe_t  strb;
  entryStatus_t status;
  logic         walkBusy;

  ptw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .pagingEn(pagingEn),
    .memReady(memReady), .status(status), .strb(strb),
    .memReq(memReq), .memWe(memWe), .walkBusy(walkBusy)
  );

  ptw_datapath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .linAddr(linAddr),
    .isWrite(isWrite), .isUser(isUser), .dirBase(dirBase),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .status(status), .physAddr(physAddr), .cacheDis(cacheDis),
    .writeThru(writeThru), .done(done), .fault(fault), .faultCode(faultCode)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              pagingEn,
  input logic              walkBusy,
  input logic              memReq,
  input logic              memWe,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] memWdata,
  input logic [ADDR_W-1:0] linAddr,
  input logic [ADDR_W-1:0] physAddr,
  input logic              done,
  input logic              fault,
  input logic [3:0]        faultCode,
  input logic              cacheDis,
  input logic              writeThru
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R12
  AST_BYPASS_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    start && !pagingEn && !walkBusy |=> done && !fault && physAddr == $past(linAddr)); // R1
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !walkBusy |-> !memReq); // R1
  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> memWdata[5]); // R7
  AST_RSV_PRESENT: assert property (@(posedge clk) disable iff (!rstN)
    done && fault && faultCode[3] |-> faultCode[0]); // R9
  AST_FAULT_NO_ATTR: assert property (@(posedge clk) disable iff (!rstN)
    done && fault |-> !cacheDis && !writeThru); // R11
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .pagingEn(pagingEn), .walkBusy(walkBusy),
  .memReq(memReq), .memWe(memWe), .memReady(memReady), .memAddr(memAddr),
  .memWdata(memWdata), .linAddr(linAddr), .physAddr(physAddr), .done(done),
  .fault(fault), .faultCode(faultCode), .cacheDis(cacheDis), .writeThru(writeThru)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic clk = 1'b0, rstN = 1'b0;
  logic start = 1'b0, isWrite = 1'b0, isUser = 1'b0, pagingEn = 1'b0;
  logic [31:0] linAddr = '0, dirBase = BASE;
  logic memReq, memWe, memReady = 1'b0;
  logic [31:0] memAddr, memWdata, memRdata = '0;
  logic [31:0] physAddr;
  logic cacheDis, writeThru, done, fault;
  logic [3:0] faultCode;

  int nChecks = 0, nFails = 0;
  int nRd = 0, nWr = 0, txCount = 0, waitCnt = 0;
  bit walkActive = 0;
  logic [31:0] mem    [logic [31:0]];
  logic [31:0] expMem [logic [31:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rstN(rstN), .start(start), .linAddr(linAddr), .isWrite(isWrite),
    .isUser(isUser), .pagingEn(pagingEn), .dirBase(dirBase), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memReady(memReady),
    .memRdata(memRdata), .physAddr(physAddr), .cacheDis(cacheDis),
    .writeThru(writeThru), .done(done), .fault(fault), .faultCode(faultCode)
  );

  // memory model: variable latency, data presented between edges
  always @(negedge clk) begin
    memRdata = mem.exists(memAddr) ? mem[memAddr] : 32'h0;
    if (memReq) begin
      if (waitCnt == 0) memReady = 1'b1;
      else begin memReady = 1'b0; waitCnt = waitCnt - 1; end
    end else memReady = 1'b0;
  end

  always @(posedge clk) begin
    if (rstN && memReq && memReady) begin
      if (memWe) begin mem[memAddr] = memWdata; nWr++; end
      else nRd++;
      txCount++;
      waitCnt = txCount % 3;
    end
  end

  // per-clock comparison: completion only while a walk is outstanding
  always @(negedge clk) begin
    if (rstN && done && !walkActive) begin
      nChecks++; nFails++;
      $display("FAIL R12 unexpected done: act=1 exp=0");
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic setEnt(logic [31:0] a, logic [31:0] v);
    mem[a] = v; expMem[a] = v;
  endtask

  function automatic logic [31:0] rdExp(logic [31:0] a);
    return expMem.exists(a) ? expMem[a] : 32'h0;
  endfunction

  task automatic walk(string tag, logic [31:0] la, bit wr, bit usr, bit pg);
    logic [31:0] pdeA, pteA, pde, pte, ePhys;
    bit eFault, eCd, eWt;
    logic [3:0] eCode;
    int eRd, eWr, r0, w0, cyc;
    pdeA = {BASE[31:12], la[31:22], 2'b00};
    pteA = 32'h0; ePhys = 32'h0; eFault = 0; eCode = 4'h0; eCd = 0; eWt = 0;
    eRd = 0; eWr = 0;
    if (!pg) ePhys = la;
    else begin
      pde = rdExp(pdeA); eRd = 1;
      if (!pde[0]) begin eFault = 1; eCode = {1'b0, usr, wr, 1'b0}; end
      else if (pde[8:7] != 0) begin eFault = 1; eCode = {1'b1, usr, wr, 1'b1}; end
      else if ((wr && !pde[1]) || (usr && !pde[2])) begin eFault = 1; eCode = {1'b0, usr, wr, 1'b1}; end
      else begin
        if (!pde[5]) begin expMem[pdeA] = pde | 32'h20; eWr++; end
        pteA = {pde[31:12], la[21:12], 2'b00};
        pte = rdExp(pteA); eRd = 2;
        if (!pte[0]) begin eFault = 1; eCode = {1'b0, usr, wr, 1'b0}; end
        else if (pte[8:7] != 0) begin eFault = 1; eCode = {1'b1, usr, wr, 1'b1}; end
        else if ((wr && !pte[1]) || (usr && !pte[2])) begin eFault = 1; eCode = {1'b0, usr, wr, 1'b1}; end
        else begin
          logic [31:0] nv;
          nv = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
          if (nv != pte) begin expMem[pteA] = nv; eWr++; end
          ePhys = {pte[31:12], la[11:0]};
          eCd = pte[4]; eWt = pte[3];
        end
      end
    end
    r0 = nRd; w0 = nWr;
    @(negedge clk);
    linAddr = la; isWrite = wr; isUser = usr; pagingEn = pg; start = 1'b1; walkActive = 1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 60) begin @(negedge clk); cyc++; end
    if (!pg) chk({tag, " R1 done one cycle after start"}, 32'(cyc), 32'd0);
    chk({tag, " R12 done seen"}, 32'(done), 32'd1);
    chk({tag, " R4 R5 R6 R9 fault"}, 32'(fault), 32'(eFault));
    chk({tag, " R10 faultCode"}, 32'(faultCode), 32'(eCode));
    if (!eFault) chk({tag, " R3 physAddr"}, physAddr, ePhys);
    chk({tag, " R11 cacheDis"}, 32'(cacheDis), 32'(eCd));
    chk({tag, " R11 writeThru"}, 32'(writeThru), 32'(eWt));
    chk({tag, " R2 reads"}, 32'(nRd - r0), 32'(eRd));
    chk({tag, " R7 R8 writes"}, 32'(nWr - w0), 32'(eWr));
    if (pg) chk({tag, " R7 R8 dir entry image"}, mem.exists(pdeA) ? mem[pdeA] : 32'h0, rdExp(pdeA));
    if (pteA != 0) chk({tag, " R7 R8 table entry image"}, mem.exists(pteA) ? mem[pteA] : 32'h0, rdExp(pteA));
    @(negedge clk);
    walkActive = 0;
  endtask

  initial begin
    setEnt(BASE + 32'h004, 32'h0002_0007);  // idx 1: P W U, not accessed
    setEnt(32'h0002_0004,  32'h0005_0007);  // page for 0x00401xxx
    setEnt(BASE + 32'hFFC, 32'h0003_0027);  // idx 1023, accessed
    setEnt(32'h0003_0FFC,  32'h0007_7019);  // P, write-through, no-cache, RO, supervisor
    setEnt(BASE + 32'h00C, 32'h0004_0003);  // idx 3: P W, supervisor only
    setEnt(BASE + 32'h010, 32'h0006_0187);  // idx 4: reserved bits set
    repeat (3) @(negedge clk);
    chk("R12 reset done", 32'(done), 32'd0);
    chk("R1 reset memReq", 32'(memReq), 32'd0);
    chk("R4 reset fault", 32'(fault), 32'd0);
    rstN = 1'b1;
    walk("bypass",           32'h1234_5678, 1, 1, 0);  // R1
    walk("first read",       32'h0040_1234, 0, 1, 1);  // R2 R3 R7
    walk("repeat read",      32'h0040_1234, 0, 1, 1);  // R7 skip
    walk("write dirty",      32'h0040_1ABC, 1, 1, 1);  // R8
    walk("write again",      32'h0040_1000, 1, 0, 1);  // R8 skip
    walk("top index attrs",  32'hFFFF_FFFF, 0, 0, 1);  // R2 R11
    walk("user to super",    32'hFFFF_F000, 0, 1, 1);  // R6
    walk("write read-only",  32'hFFFF_F800, 1, 0, 1);  // R5
    walk("dir not present",  32'h0080_0000, 0, 0, 1);  // R4
    walk("user dir super",   32'h00C0_0000, 1, 1, 1);  // R6 R10
    walk("tbl not present",  32'h00C0_0000, 1, 0, 1);  // R4 R7
    walk("reserved bits",    32'h0100_0000, 0, 0, 1);  // R9
    walk("reserved user wr", 32'h0100_0000, 1, 1, 1);  // R9 priority over R5 R6
    walk("bypass low",       32'h0000_0000, 0, 0, 0);  // R1
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    nChecks++; nFails++;
    $display("FAIL R12 watchdog expired act=hung exp=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule